// File: doc/BRIEF.md
# Tick-Driven Match Timer with Watchdog Channel

This block is a free-running up-counter with a set of compare channels. An external tick enable, produced from a slow reference clock outside the block, advances the counter by one on each qualified cycle. Every channel holds a compare value. When the counter equals that value on a tick, the channel raises a sticky status flag. A flag reaches its interrupt output only when the channel's interrupt enable is set.

Three channels act as plain interval timers. The last channel can also be armed as a watchdog. Once armed, it cannot be disarmed until reset. A match on that channel then raises a dedicated reset-request output. This output is separate from the chip's ordinary hard and soft reset inputs, so reset logic downstream can record a watchdog expiry as its own cause. Software reaches every register through a simple single-cycle write port and a combinational read port.

Top module: `tmr_top`

## Requirements
- R1: After reset the counter reads 0, every compare register reads all-ones, and status, interrupt enables and the watchdog arm bit read 0. Every irq bit and wdog_rst are low.
- R2: The counter rises by exactly one on each clock edge where tick_en is high. It holds its value on edges where tick_en is low.
- R3: A tick taken while the counter is all-ones wraps it to zero.
- R4: A software write to the counter register loads wdata on that edge. The load wins over a tick in the same cycle.
- R5: A tick taken while the counter equals compare register n sets status bit n on that edge.
- R6: Status bits are write-one-to-clear. Writing 0 leaves a bit set. If a match and a clear of the same bit happen on the same edge, the bit ends up set.
- R7: irq[n] is high exactly when status bit n and interrupt enable bit n are both high.
- R8: Register addresses are as follows: compare n at address n (0 to 3), counter at 4, status at 5 (bit n = channel n), watchdog arm at 6 (bit 0), interrupt enables at 7 (bit n = channel n). Compare registers read back what was written.
- R9: Writing 1 to bit 0 of the watchdog arm register arms the watchdog. Writing 0 has no effect. Only rst_n disarms it.
- R10: When armed, a match on channel 3 drives wdog_rst high on the same edge that sets the status bit. wdog_rst then stays high until rst_n. When not armed, a channel-3 match leaves wdog_rst low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance qualifier from the reference divider |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 4 | Per-channel interrupt requests |
| wdog_rst | output | 1 | Watchdog reset request, held until reset |

## Verification
Every register update lands on the edge after the write strobe or tick that caused it. The read port is combinational, so a value written or ticked in one cycle can be read in the very next cycle. irq follows status and enables with no extra delay, and wdog_rst rises on the same edge as the channel-3 status bit. The bench drives inputs 1 ns after each rising edge and samples 3 ns after it. Each expected item is queued in the cycle whose registered state it describes, so every comparison falls after all the edges that feed it.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   // control registers sit directly above the compare registers
   typedef enum int {
      OFS_COUNT  = 0,
      OFS_STATUS = 1,
      OFS_ARM    = 2,
      OFS_IEN    = 3
   } ctrl_ofs_e;
   localparam int NUM_CTRL_REGS = 4;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (tick) count <= count + CNT_W'(1);
   end
endmodule

// File: rtl/tmr_match_chan.sv
`timescale 1ns/1ps
module tmr_match_chan #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cmp,
   input  logic [CNT_W-1:0] wdata,
   input  logic             tick,
   input  logic [CNT_W-1:0] count,
   input  logic             clr,
   input  logic             ien,
   output logic [CNT_W-1:0] cmp,
   output logic             hit,
   output logic             flag,
   output logic             irq
);
   assign hit = tick && (count == cmp);
   assign irq = flag & ien;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp <= '1;
      else if (wr_cmp) cmp <= wdata;
   end

   // a match on the same edge as a clear leaves the flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/tmr_wdog.sv
`timescale 1ns/1ps
module tmr_wdog (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   input  logic hit,
   output logic armed,
   output logic fire
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         fire  <= 1'b0;
      end else begin
         armed <= armed | arm_set;
         fire  <= fire | (armed & hit);
      end
   end
endmodule

// File: rtl/tmr_top.sv
`timescale 1ns/1ps
module tmr_top
   import tmr_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int NUM_CH   = 4,
   parameter int WDOG_CH  = 3,
   parameter bit HAS_WDOG = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_CH + NUM_CTRL_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic [NUM_CH-1:0] irq,
   output logic              wdog_rst
);
   localparam int A_COUNT  = NUM_CH + OFS_COUNT;
   localparam int A_STATUS = NUM_CH + OFS_STATUS;
   localparam int A_ARM    = NUM_CH + OFS_ARM;
   localparam int A_IEN    = NUM_CH + OFS_IEN;

   if (NUM_CH < 1 || NUM_CH > CNT_W) begin : g_bad_ch
      $error("tmr_top: NUM_CH must lie in 1..CNT_W");
   end
   if (WDOG_CH < 0 || WDOG_CH >= NUM_CH) begin : g_bad_wd
      $error("tmr_top: WDOG_CH must name an existing channel");
   end
   if (CNT_W < 2) begin : g_bad_w
      $error("tmr_top: CNT_W too small");
   end

   logic [CNT_W-1:0]  count_q;
   logic [CNT_W-1:0]  cmp_q [NUM_CH];
   logic [NUM_CH-1:0] status_q;
   logic [NUM_CH-1:0] ien_q;
   logic [NUM_CH-1:0] hit;
   logic              wdog_armed;
   logic              wdog_fire;

   logic wr_count, wr_status, wr_arm, wr_ien;
   assign wr_count  = wr_en && (addr == ADDR_W'(A_COUNT));
   assign wr_status = wr_en && (addr == ADDR_W'(A_STATUS));
   assign wr_arm    = wr_en && (addr == ADDR_W'(A_ARM));
   assign wr_ien    = wr_en && (addr == ADDR_W'(A_IEN));

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en),
      .load     (wr_count),
      .load_val (wdata),
      .count    (count_q)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_match_chan #(.CNT_W(CNT_W)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_cmp (wr_en && (addr == ADDR_W'(i))),
         .wdata  (wdata),
         .tick   (tick_en),
         .count  (count_q),
         .clr    (wr_status && wdata[i]),
         .ien    (ien_q[i]),
         .cmp    (cmp_q[i]),
         .hit    (hit[i]),
         .flag   (status_q[i]),
         .irq    (irq[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= '0;
      else if (wr_ien) ien_q <= wdata[NUM_CH-1:0];
   end

   if (HAS_WDOG) begin : g_wdog
      tmr_wdog u_wd (
         .clk     (clk),
         .rst_n   (rst_n),
         .arm_set (wr_arm && wdata[0]),
         .hit     (hit[WDOG_CH]),
         .armed   (wdog_armed),
         .fire    (wdog_fire)
      );
   end else begin : g_no_wdog
      assign wdog_armed = 1'b0;
      assign wdog_fire  = 1'b0;
   end

   assign wdog_rst = wdog_fire;

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(i)) rdata = cmp_q[i];
      end
      if (addr == ADDR_W'(A_COUNT))  rdata = count_q;
      if (addr == ADDR_W'(A_STATUS)) rdata = CNT_W'(status_q);
      if (addr == ADDR_W'(A_ARM))    rdata = CNT_W'(wdog_armed);
      if (addr == ADDR_W'(A_IEN))    rdata = CNT_W'(ien_q);
   end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker #(
   parameter int CNT_W  = 32,
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  wdata,
   input logic [CNT_W-1:0]  count,
   input logic [NUM_CH-1:0] status,
   input logic [NUM_CH-1:0] ien,
   input logic [NUM_CH-1:0] irq,
   input logic              armed,
   input logic              wdog_rst
);
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(NUM_CH);
   localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(NUM_CH + 1);

   logic load;
   assign load = wr_en && (addr == A_CNT);

   // R2 / R3: step by one, modulo the counter width
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !load) |=> (count == CNT_W'($past(count) + CNT_W'(1))));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load) |=> $stable(count));

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(wdata)));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
      p_flag_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !(wr_en && addr == A_ST && wdata[i])) |=> status[i]);
   end

   p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~(status & ien)) == '0));

   p_arm_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);

   p_fire_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst |=> wdog_rst);

   p_fire_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdog_rst) |-> $past(armed));
endmodule

bind tmr_top tmr_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_en  (tick_en),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .count    (count_q),
   .status   (status_q),
   .ien      (ien_q),
   .irq      (irq),
   .armed    (wdog_armed),
   .wdog_rst (wdog_rst)
);

// File: tb/tmr_top_test.sv
`timescale 1ns/1ps
module tmr_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;
   logic        wdog_rst;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      int          kind;   // 0 rdata, 1 irq, 2 wdog_rst
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   tmr_top uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
   );

   // monitor: compare queued items 3 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #3;
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
               0:       act = rdata;
               1:       act = {28'd0, irq};
               default: act = {31'd0, wdog_rst};
            endcase
            tests++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d, input logic tk);
      @(posedge clk);
      #1;
      wr_en = we; addr = a; wdata = d; tick_en = tk;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 1'b1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, 1'b0);
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
      item_t it;
      step(1'b0, a, 32'd0, 1'b0);
      it.kind = 0; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic chk_irq(input logic [3:0] e, input string tag);
      item_t it;
      idle(1);
      it.kind = 1; it.exp = {28'd0, e}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic chk_wd(input logic e, input string tag);
      item_t it;
      idle(1);
      it.kind = 2; it.exp = {31'd0, e}; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic do_reset();
      @(posedge clk);
      #1;
      rst_n = 1'b0; wr_en = 1'b0; tick_en = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd4, 32'h0, "R1 count");
      rd(3'd5, 32'h0, "R1 status");
      rd(3'd7, 32'h0, "R1 ien");
      rd(3'd6, 32'h0, "R1 arm");
      rd(3'd0, 32'hFFFF_FFFF, "R1 compare0");
      rd(3'd3, 32'hFFFF_FFFF, "R1 compare3");
      chk_irq(4'h0, "R1 irq");
      chk_wd(1'b0, "R1 wdog_rst");

      // R8 compare readback
      wr(3'd0, 32'd5);
      rd(3'd0, 32'd5, "R8 compare0");
      wr(3'd1, 32'hA5A5_0003);
      rd(3'd1, 32'hA5A5_0003, "R8 compare1");

      // R2 tick and hold
      wr(3'd4, 32'd0);
      tick(3);
      rd(3'd4, 32'd3, "R2 three ticks");
      idle(4);
      rd(3'd4, 32'd3, "R2 hold without tick");

      // R5 match on tick at count 5
      tick(2);
      rd(3'd5, 32'h0, "R5 no flag before tick at match");
      tick(1);
      rd(3'd5, 32'h1, "R5 flag after tick at match");
      rd(3'd4, 32'd6, "R2 count past match");
      chk_irq(4'h0, "R7 masked");
      wr(3'd7, 32'h1);
      chk_irq(4'h1, "R7 enabled");
      wr(3'd5, 32'h0);
      rd(3'd5, 32'h1, "R6 write zero keeps");
      chk_irq(4'h1, "R7 still high");
      wr(3'd5, 32'h1);
      rd(3'd5, 32'h0, "R6 write one clears");
      chk_irq(4'h0, "R7 low after clear");

      // R4 load beats tick, R3 wrap
      step(1'b1, 3'd4, 32'hFFFF_FFFE, 1'b1);
      rd(3'd4, 32'hFFFF_FFFE, "R4 load over tick");
      tick(1);
      rd(3'd4, 32'hFFFF_FFFF, "R2 to all ones");
      tick(1);
      rd(3'd4, 32'h0, "R3 wrap");
      rd(3'd5, 32'hC, "R5 all-ones compares matched");
      wr(3'd5, 32'hF);
      rd(3'd5, 32'h0, "R6 clear all");

      // R6 set wins over clear
      wr(3'd2, 32'd10);
      wr(3'd4, 32'd10);
      step(1'b1, 3'd5, 32'h4, 1'b1);
      rd(3'd5, 32'h4, "R6 set beats clear");
      rd(3'd4, 32'd11, "R2 tick during status write");
      chk_irq(4'h0, "R7 disabled channel 2");

      // R10 unarmed match
      wr(3'd5, 32'hF);
      wr(3'd3, 32'd20);
      wr(3'd4, 32'd20);
      tick(1);
      rd(3'd5, 32'h8, "R5 channel 3 flag");
      chk_wd(1'b0, "R10 unarmed no reset");

      // R9 arm behaviour
      wr(3'd5, 32'hF);
      wr(3'd6, 32'h0);
      rd(3'd6, 32'h0, "R9 zero does not arm");
      wr(3'd6, 32'h1);
      rd(3'd6, 32'h1, "R9 armed");
      wr(3'd6, 32'h0);
      rd(3'd6, 32'h1, "R9 cannot disarm");

      // R10 armed expiry
      wr(3'd4, 32'd20);
      chk_wd(1'b0, "R10 before match");
      wr(3'd4, 32'd20);
      tick(1);
      chk_wd(1'b1, "R10 fires");
      idle(3);
      chk_wd(1'b1, "R10 held");

      do_reset();
      chk_wd(1'b0, "R10 cleared by reset");
      rd(3'd6, 32'h0, "R9 disarmed by reset");
      rd(3'd4, 32'h0, "R1 count after reset");

      idle(2);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule